// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave for a Clock Generator

This block is a two-wire serial slave that fills a small bank of byte-wide control registers for a clock generator. It runs on a system clock that is much faster than SCL and oversamples both bus lines. A write transfer starts with the 7-bit device address. Two placeholder bytes come next, and the block acknowledges both and throws them away. The data bytes after that land in the registers in strict ascending order from register 0, until a STOP or a new START. There is no register pointer that the master can set.

A read transfer returns the registers, starting at register 0 and going upward, MSB first, for as long as the master acknowledges each byte. The register contents are exposed continuously as outputs. The low six bits of register 0 form the frequency select code that picks one of 64 operating points. The remaining bits can be used as per-output enable, stop or tri-state controls.

The bus side is open drain. The block only ever pulls SDA low, through `sda_oe_o`. The SDA and SCL lines are plain level inputs with no back-pressure, so the pace of the transfer is set entirely by the master's SCL.

Top module: `i2c_clkcfg_slave`

## Requirements
- R1: While `rst_n` is low, every register takes its value from parameter `RESET_VAL` (register k from bits 8k+7:8k) and `sda_oe_o` is 0. No bus event ever reloads these defaults.
- R2: The first byte after a START is received MSB first. If its bits 7:1 equal `DEV_ADDR`, the block pulls SDA low during the ninth SCL clock, and bit 0 = 1 selects a read. If they differ, no ACK is given and the bus is ignored until the next START.
- R3: In a write, the two bytes that follow the address are each acknowledged and discarded. Neither is stored in any register.
- R4: Each later data byte is acknowledged and stored in register 0, 1, 2, and so on in that order. Register k appears on `regs_o[8k+7:8k]`.
- R5: Data bytes beyond register `NUM_REGS-1` are acknowledged and discarded. They do not wrap to register 0.
- R6: In a read, the block sends register 0 first and then each following register after every master ACK, MSB first. Bytes requested past the last register read as 0x00.
- R7: After the master answers a read byte with NACK, SDA stays released until the next START.
- R8: A START or STOP at any point aborts the transfer. Bytes already completed keep their stored values, and a partly received byte is not stored.
- R9: `sda_oe_o` is only asserted while SCL is low.
- R10: `freq_sel_o` always equals register 0 bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | NUM_REGS*8 | Register bank contents, register k in bits 8k+7:8k |
| freq_sel_o | output | FSEL_W | Frequency select code from register 0 |

## Verification
The random writes vary the number of data bytes from zero up to beyond the bank size, and the placeholder bytes are random as well. This shows whether the placeholder bytes ever leak into the registers, and whether the pointer saturates or wraps. Random read lengths with a NACK on the final byte check the register order, the zero fill past the end, and the release of SDA. A directed foreign address, a repeated START inside a data byte and a STOP inside a byte separate an abort that keeps completed bytes from one that drops them or stores the partial byte. A final reset shows that only reset restores the defaults.

// File: rtl/i2c_clkcfg_pkg.sv
package i2c_clkcfg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_RXEND, PH_ACK, PH_TX, PH_MACK, PH_TXLOAD
  } phase_t;

  typedef enum logic [1:0] {
    K_ADDR, K_CMD, K_CNT, K_DATA
  } kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] last;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= '1;
    else        last <= synced;
  end

  assign scl_s     = synced[1];
  assign sda_s     = synced[0];
  assign scl_rise  = synced[1] & ~last[1];
  assign scl_fall  = ~synced[1] & last[1];
  assign start_det = synced[1] & last[1] & last[0] & ~synced[0];
  assign stop_det  = synced[1] & last[1] & ~last[0] & synced[0];
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank #(
  parameter int                    NUM_REGS  = 8,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = '0,
  localparam int PW = $clog2(NUM_REGS + 1),
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [PW-1:0]         rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  localparam logic [PW-1:0] LIMIT = PW'(NUM_REGS);
  logic [7:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= RESET_VAL[i*8 +: 8];
    end else if (wr_en) begin
      regs[wr_idx] <= wr_data;
    end
  end

  assign rd_data = (rd_idx < LIMIT) ? regs[rd_idx[IW-1:0]] : 8'h00;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = regs[g];
  end

  // R4: an accepted write is visible in the addressed register one cycle later
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> regs[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
  import i2c_clkcfg_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int PW = $clog2(NUM_REGS + 1),
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [PW-1:0] rd_idx,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  localparam logic [PW-1:0] LIMIT = PW'(NUM_REGS);

  phase_t     phase;
  kind_t      kind;
  logic [2:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] tx_sh;
  logic [PW-1:0] ptr;
  logic       rd_mode;

  assign rd_idx = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      kind    <= K_ADDR;
      bitcnt  <= '0;
      shreg   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      rd_mode <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase   <= PH_RX;
        kind    <= K_ADDR;
        bitcnt  <= '0;
        ptr     <= '0;
        rd_mode <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (phase)
          PH_RX: if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            if (bitcnt == 3'd7) begin
              bitcnt <= '0;
              phase  <= PH_RXEND;
            end else begin
              bitcnt <= bitcnt + 3'd1;
            end
          end
          PH_RXEND: if (scl_fall) begin
            if (kind == K_ADDR && shreg[7:1] != DEV_ADDR) begin
              phase <= PH_IDLE;
            end else begin
              sda_oe <= 1'b1;
              phase  <= PH_ACK;
              if (kind == K_ADDR) rd_mode <= shreg[0];
              if (kind == K_DATA && ptr < LIMIT) begin
                wr_en   <= 1'b1;
                wr_idx  <= ptr[IW-1:0];
                wr_data <= shreg;
                ptr     <= ptr + 1'b1;
              end
            end
          end
          PH_ACK: if (scl_fall) begin
            if (rd_mode) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
              bitcnt <= '0;
              phase  <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_RX;
              kind   <= (kind == K_ADDR) ? K_CMD :
                        (kind == K_CMD)  ? K_CNT : K_DATA;
            end
          end
          PH_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              phase  <= PH_MACK;
            end else begin
              bitcnt <= bitcnt + 3'd1;
              sda_oe <= ~tx_sh[6];
              tx_sh  <= {tx_sh[6:0], 1'b0};
            end
          end
          PH_MACK: if (scl_rise) begin
            if (sda_s) begin
              phase <= PH_IDLE;
            end else begin
              phase <= PH_TXLOAD;
              if (ptr < LIMIT) ptr <= ptr + 1'b1;
            end
          end
          PH_TXLOAD: if (scl_fall) begin
            tx_sh  <= rd_data;
            sda_oe <= ~rd_data[7];
            bitcnt <= '0;
            phase  <= PH_TX;
          end
          default: ;
        endcase
      end
    end
  end

  // R9: SDA is only pulled low after SCL has been seen low
  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));
  // R7: the idle phase never pulls the bus
  p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);
  // R5: the register pointer saturates one past the last register
  p_ptr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LIMIT);
  // R8: a START always leaves SDA released
  p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> !sda_oe);
endmodule

// File: rtl/i2c_clkcfg_slave.sv
module i2c_clkcfg_slave #(
  parameter int                    NUM_REGS  = 8,
  parameter logic [6:0]            DEV_ADDR  = 7'h69,
  parameter int                    FSEL_W    = 6,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = 64'hFFFF_FFFF_FFFF_FF0A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic [FSEL_W-1:0]     freq_sel_o
);
  localparam int PW = $clog2(NUM_REGS + 1);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]    rd_data, wr_data;
  logic [PW-1:0] rd_idx;
  logic [IW-1:0] wr_idx;
  logic          wr_en;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_cfg_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  i2c_cfg_bank #(.NUM_REGS(NUM_REGS), .RESET_VAL(RESET_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .regs_flat(regs_o)
  );

  assign freq_sel_o = regs_o[FSEL_W-1:0];
endmodule

// File: tb/i2c_clkcfg_slave_bench.sv
module i2c_clkcfg_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int Q = 5;
  localparam logic [6:0] ADDR = 7'h69;
  localparam logic [NREG*8-1:0] RST = 64'h3C5A_9600_F00F_A50A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  logic [5:0] fsel;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int failures = 0;
  int r9_viol = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;
  logic [7:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_clkcfg_slave #(.NUM_REGS(NREG), .DEV_ADDR(ADDR), .FSEL_W(6), .RESET_VAL(RST))
    u_i2c_clkcfg_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .regs_o(regs), .freq_sel_o(fsel));

  // R9 monitor: a new SDA pull must never start while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl) r9_viol++;
    oe_prev = sda_oe;
  end

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  function automatic logic [7:0] exp_rd(int k);
    return (k < NREG) ? model[k] : 8'h00;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(logic b, output logic smp);
    tick(Q); sda_m = b;
    tick(Q); scl = 1'b1;
    tick(Q); smp = sda_line;
    tick(Q); scl = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0;
    tick(Q); scl = 1'b1;
    tick(Q); sda_m = 1'b1;
    tick(2*Q);
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      d[i] = s;
    end
    bit_io(!mack, s);
  endtask

  task automatic do_write(int ndata);
    logic ack;
    logic [7:0] d;
    bus_start();
    wr_byte({ADDR, 1'b0}, ack); chk("R2 address ack", 64'(ack), 64'd1);
    wr_byte(8'($urandom), ack);  chk("R3 command ack", 64'(ack), 64'd1);
    wr_byte(8'($urandom), ack);  chk("R3 count ack", 64'(ack), 64'd1);
    for (int k = 0; k < ndata; k++) begin
      d = 8'($urandom);
      wr_byte(d, ack);
      chk((k < NREG) ? "R4 data ack" : "R5 extra ack", 64'(ack), 64'd1);
      if (k < NREG) model[k] = d;
    end
    bus_stop();
    chk((ndata > NREG) ? "R5 no wrap" : "R4 registers", 64'(regs), 64'(model_flat()));
    chk("R10 freq select", 64'(fsel), 64'(model[0][5:0]));
  endtask

  task automatic do_read(int nbytes);
    logic ack, s;
    logic [7:0] d;
    bus_start();
    wr_byte({ADDR, 1'b1}, ack); chk("R2 read address ack", 64'(ack), 64'd1);
    for (int k = 0; k < nbytes; k++) begin
      rd_byte(k < nbytes - 1, d);
      chk("R6 read data", 64'(d), 64'(exp_rd(k)));
    end
    bit_io(1'b1, s);
    chk("R7 released after NACK", 64'(s), 64'd1);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack, s;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) model[i] = RST[i*8 +: 8];
    tick(4);
    chk("R1 reset registers", 64'(regs), 64'(RST));
    chk("R1 reset sda", 64'(sda_oe), 64'd0);
    rst_n = 1'b1;
    tick(4);
    chk("R10 reset freq select", 64'(fsel), 64'(RST[5:0]));

    // R2: foreign address, no ack, following bytes ignored
    bus_start();
    wr_byte({ADDR ^ 7'h01, 1'b0}, ack); chk("R2 foreign no ack", 64'(ack), 64'd0);
    wr_byte(8'h00, ack); wr_byte(8'h00, ack); wr_byte(8'h55, ack);
    chk("R2 ignored data no ack", 64'(ack), 64'd0);
    bus_stop();
    chk("R2 foreign unchanged", 64'(regs), 64'(model_flat()));

    // R3: placeholders only, nothing stored
    do_write(0);
    // R5: overrun past last register
    do_write(NREG + 3);
    do_read(NREG + 2);

    // R8: repeated START inside third data byte
    bus_start();
    wr_byte({ADDR, 1'b0}, ack); wr_byte(8'h11, ack); wr_byte(8'h22, ack);
    wr_byte(8'hC3, ack); model[0] = 8'hC3;
    wr_byte(8'h7E, ack); model[1] = 8'h7E;
    bit_io(1'b0, s); bit_io(1'b1, s); bit_io(1'b0, s);
    bus_start();
    bus_stop();
    chk("R8 start abort keeps done bytes", 64'(regs), 64'(model_flat()));
    chk("R8 sda released", 64'(sda_oe), 64'd0);

    // R8: STOP inside the first data byte
    bus_start();
    wr_byte({ADDR, 1'b0}, ack); wr_byte(8'h00, ack); wr_byte(8'h00, ack);
    bit_io(1'b0, s); bit_io(1'b0, s);
    bus_stop();
    chk("R8 stop abort no store", 64'(regs), 64'(model_flat()));

    for (int it = 0; it < 10; it++) begin
      do_write(int'($urandom_range(0, NREG + 2)));
      do_read(int'($urandom_range(1, NREG + 1)));
    end

    chk("R9 drive only with SCL low", 64'(r9_viol), 64'd0);

    // R1: only reset restores defaults
    tick(2); rst_n = 1'b0; tick(2);
    chk("R1 reset reloads defaults", 64'(regs), 64'(RST));
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule